// File: doc/BRIEF.md
# CAN Start-of-Frame Detector with Glitch Filter

This block watches the receive line of a CAN bus and marks the start of each frame with a single-cycle pulse. While the bus is reported idle it waits for the line to fall from recessive (1) to dominant (0). It then counts time quanta from that edge up to a programmable sample position. If the line is still dominant at that point, the block reports a start of frame. If the line goes recessive again first, the event is a glitch. A glitch gives no start-of-frame pulse and raises a separate one-cycle glitch pulse, which can be used to track bus health.

The receive input is asynchronous and passes through a two-flop synchroniser before edge detection. A time-quantum strobe from an external bit-timing unit drives the internal quantum counter. After a start of frame the detector stays in the in-frame state until the bus-idle input is asserted again. Only then does it re-arm.

Top module: `can_sof_detect`

## Requirements
- R1: After reset both output pulses are low, and the detector is armed for a new edge.
- R2: A recessive-to-dominant change on the synchronised line, with the dominant level still present when the sample position is reached, gives exactly one start-of-frame pulse. With a quantum strobe on every clock and the input falling just before clock edge 1, the pulse is visible after clock edge S+3, where S is the effective sample position.
- R3: If the line is recessive again at or before the sample position, the event is a glitch. One glitch pulse appears and no start-of-frame pulse. With a strobe on every clock and the input low for L clock edges, the glitch pulse is visible after edge min(L,S)+3.
- R4: While `sof_en` is 0, no start-of-frame pulse is produced. Glitch pulses are still reported.
- R5: A falling edge is accepted only while `bus_idle` is 1. An edge seen while it is 0 produces neither pulse.
- R6: After a start of frame, further edges are ignored until `bus_idle` is asserted. The next accepted edge after that produces a new pulse.
- R7: After a glitch the detector is armed again, so a later real edge is detected.
- R8: `cfg_sample_tq` gives the sample position as a count of quanta after the edge. A value of 0 acts as 1. Values of TQ_PER_BIT or more act as TQ_PER_BIT-1; the default TQ_PER_BIT is 10.
- R9: The quantum counter advances only on clocks where `tq_tick` is 1.
- R10: Each pulse lasts exactly one clock, and the two pulses are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Raw bus receive level, 1 = recessive |
| sof_en | input | 1 | Enables start-of-frame reporting |
| bus_idle | input | 1 | Bus-idle indication, arms the detector |
| tq_tick | input | 1 | One-clock time-quantum strobe |
| cfg_sample_tq | input | TQ_W (4) | Sample position in quanta after the edge |
| sof_pulse | output | 1 | One-cycle start-of-frame pulse |
| glitch_pulse | output | 1 | One-cycle glitch pulse |

## Verification
The bench moves the dominant pulse length across the sample position. A pulse exactly S quanta long must count as a glitch, and one quantum longer must count as a frame. A detector that qualified on the edge alone, or that sampled one cycle off, would fail at one of these two lengths. Out-of-range sample settings test the clamp, and a timer that ignored the limits would fire at 3 or never. A halved quantum rate shows whether the counter advances on every clock instead of on the strobe. Edges during a frame, or while the bus is busy, show whether the design re-arms too early.

// File: rtl/can_sof_pkg.sv
package can_sof_pkg;

  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_EDGE  = 2'd1,
    ST_FRAME = 2'd2
  } sof_state_e;

  // Map a programmed sample position to the one actually used
  function automatic int unsigned eff_sample_tq(input int unsigned cfg,
                                                input int unsigned tq_per_bit);
    if (cfg == 0) return 1;
    if (cfg >= tq_per_bit) return tq_per_bit - 1;
    return cfg;
  endfunction

endpackage

// File: rtl/sof_sync.sv
module sof_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_in,
  output logic rx_sync,
  output logic fall_edge
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[i] <= 1'b1;
          else        chain_q[i] <= rx_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[i] <= 1'b1;
          else        chain_q[i] <= chain_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= chain_q[STAGES-1];

  assign rx_sync   = chain_q[STAGES-1];
  assign fall_edge = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/sof_tq_timer.sv
module sof_tq_timer #(
  parameter int TQ_PER_BIT = 10,
  localparam int TQ_W = $clog2(TQ_PER_BIT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            run,
  input  logic            tq_tick,
  input  logic [TQ_W-1:0] cfg_sample_tq,
  output logic            sample_hit
);
  import can_sof_pkg::*;

  logic [TQ_W-1:0] cnt_q;
  int unsigned     target;

  always_comb target = eff_sample_tq(32'(cfg_sample_tq), TQ_PER_BIT);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                cnt_q <= '0;
    else if (start)            cnt_q <= '0;
    else if (run && tq_tick)   cnt_q <= cnt_q + 1'b1;

  assign sample_hit = run && tq_tick && ((32'(cnt_q) + 32'd1) == target);
endmodule

// File: rtl/sof_fsm.sv
module sof_fsm (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fall_edge,
  input  logic                    rx_sync,
  input  logic                    bus_idle,
  input  logic                    sof_en,
  input  logic                    sample_hit,
  output can_sof_pkg::sof_state_e state_q,
  output logic                    arm_accept,
  output logic                    sof_pulse,
  output logic                    glitch_pulse
);
  import can_sof_pkg::*;

  sof_state_e state_d;
  logic       sof_d, glitch_d;

  assign arm_accept = (state_q == ST_ARMED) && fall_edge && bus_idle;

  always_comb begin
    state_d  = state_q;
    sof_d    = 1'b0;
    glitch_d = 1'b0;
    unique case (state_q)
      ST_ARMED: if (arm_accept) state_d = ST_EDGE;
      ST_EDGE: begin
        if (rx_sync) begin
          glitch_d = 1'b1;
          state_d  = ST_ARMED;
        end else if (sample_hit) begin
          sof_d   = sof_en;
          state_d = ST_FRAME;
        end
      end
      ST_FRAME: if (bus_idle) state_d = ST_ARMED;
      default:  state_d = ST_ARMED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state_q      <= ST_ARMED;
      sof_pulse    <= 1'b0;
      glitch_pulse <= 1'b0;
    end else begin
      state_q      <= state_d;
      sof_pulse    <= sof_d;
      glitch_pulse <= glitch_d;
    end
endmodule

// File: rtl/can_sof_detect.sv
module can_sof_detect #(
  parameter int TQ_PER_BIT  = 10,
  parameter int SYNC_STAGES = 2,
  localparam int TQ_W = $clog2(TQ_PER_BIT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_in,
  input  logic            sof_en,
  input  logic            bus_idle,
  input  logic            tq_tick,
  input  logic [TQ_W-1:0] cfg_sample_tq,
  output logic            sof_pulse,
  output logic            glitch_pulse
);
  import can_sof_pkg::*;

  logic       rx_sync, fall_edge, arm_accept, sample_hit, timer_run;
  sof_state_e fsm_state;

  sof_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in),
    .rx_sync(rx_sync), .fall_edge(fall_edge)
  );

  assign timer_run = (fsm_state == ST_EDGE);

  sof_tq_timer #(.TQ_PER_BIT(TQ_PER_BIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(arm_accept), .run(timer_run),
    .tq_tick(tq_tick), .cfg_sample_tq(cfg_sample_tq), .sample_hit(sample_hit)
  );

  sof_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .fall_edge(fall_edge), .rx_sync(rx_sync),
    .bus_idle(bus_idle), .sof_en(sof_en), .sample_hit(sample_hit),
    .state_q(fsm_state), .arm_accept(arm_accept),
    .sof_pulse(sof_pulse), .glitch_pulse(glitch_pulse)
  );
endmodule

// File: rtl/can_sof_detect_chk.sv
module can_sof_detect_chk (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sof_en,
  input logic                    bus_idle,
  input logic                    tq_tick,
  input logic                    rx_sync,
  input can_sof_pkg::sof_state_e fsm_state,
  input logic                    sof_pulse,
  input logic                    glitch_pulse
);
  import can_sof_pkg::*;

  assert_sof_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sof_pulse |=> !sof_pulse);

  assert_glitch_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    glitch_pulse |=> !glitch_pulse);

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(sof_pulse && glitch_pulse));

  assert_sof_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sof_pulse |-> $past(sof_en));

  assert_sof_dominant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sof_pulse |-> ($past(rx_sync) == 1'b0));

  assert_arm_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_state == ST_EDGE && $past(fsm_state) == ST_ARMED) |-> $past(bus_idle));

  assert_glitch_rearm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    glitch_pulse |-> (fsm_state == ST_ARMED));

  assert_frame_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_state == ST_FRAME && !bus_idle) |=> (fsm_state == ST_FRAME));

  assert_sample_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_state == ST_FRAME && $past(fsm_state) == ST_EDGE) |-> $past(tq_tick));
endmodule

bind can_sof_detect can_sof_detect_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sof_en(sof_en), .bus_idle(bus_idle),
  .tq_tick(tq_tick), .rx_sync(rx_sync), .fsm_state(fsm_state),
  .sof_pulse(sof_pulse), .glitch_pulse(glitch_pulse)
);

// File: tb/can_sof_detect_tb.sv
module can_sof_detect_tb;
  localparam int TQ = 10;
  localparam int TW = $clog2(TQ + 1);
  localparam int WIN = 40;

  logic clk = 1'b0, rst_n = 1'b0, rx_in = 1'b1, sof_en = 1'b1, bus_idle = 1'b1;
  logic tq_tick = 1'b1, tick_half = 1'b0;
  logic [TW-1:0] cfg = TW'(8);
  logic sof_pulse, glitch_pulse;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  always @(negedge clk) tq_tick <= tick_half ? ~tq_tick : 1'b1;

  can_sof_detect #(.TQ_PER_BIT(TQ)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .sof_en(sof_en),
    .bus_idle(bus_idle), .tq_tick(tq_tick), .cfg_sample_tq(cfg),
    .sof_pulse(sof_pulse), .glitch_pulse(glitch_pulse)
  );

  typedef struct packed {
    logic [7:0] cfg;
    logic [7:0] len;
    logic       en;
    logic       idle;
    logic       xs;
    logic       xg;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{8'd8,  8'd20, 1'b1, 1'b1, 1'b1, 1'b0},  // R2 real frame
    '{8'd8,  8'd3,  1'b1, 1'b1, 1'b0, 1'b1},  // R3 short glitch
    '{8'd8,  8'd8,  1'b1, 1'b1, 1'b0, 1'b1},  // R3 ends at sample point
    '{8'd8,  8'd9,  1'b1, 1'b1, 1'b1, 1'b0},  // R3 one past sample point
    '{8'd8,  8'd20, 1'b0, 1'b1, 1'b0, 1'b0},  // R4 disabled frame
    '{8'd8,  8'd3,  1'b0, 1'b1, 1'b0, 1'b1},  // R4 glitch still reported
    '{8'd8,  8'd20, 1'b1, 1'b0, 1'b0, 1'b0},  // R5 bus busy
    '{8'd3,  8'd20, 1'b1, 1'b1, 1'b1, 1'b0},  // R8 early sample
    '{8'd0,  8'd20, 1'b1, 1'b1, 1'b1, 1'b0},  // R8 zero acts as one
    '{8'd15, 8'd20, 1'b1, 1'b1, 1'b1, 1'b0},  // R8 clamp high
    '{8'd4,  8'd1,  1'b1, 1'b1, 1'b0, 1'b1},  // R7 glitch first
    '{8'd4,  8'd20, 1'b1, 1'b1, 1'b1, 1'b0}   // R7 then a real edge
  };

  function automatic int used_pos(input int c);
    int r;
    r = c;
    if (r < 1) r = 1;
    if (r > TQ - 1) r = TQ - 1;
    return r;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle(input int cycles);
    rx_in = 1'b1;
    bus_idle = 1'b1;
    repeat (cycles) @(negedge clk);
  endtask

  // Drive the line low for len edges; observe win edges
  task automatic pulse_run(input int len, input int win, input bit drop_idle,
                           output int ns, output int fs, output int ng, output int fg);
    ns = 0; fs = 0; ng = 0; fg = 0;
    rx_in = 1'b0;
    for (int n = 1; n <= win; n++) begin
      @(negedge clk);
      if (sof_pulse) begin
        ns++;
        if (fs == 0) fs = n;
        if (drop_idle) bus_idle = 1'b0;
      end
      if (glitch_pulse) begin
        ng++;
        if (fg == 0) fg = n;
      end
      if (n == len) rx_in = 1'b1;
    end
    rx_in = 1'b1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int ns, fs, ng, fg, p, eg;
    repeat (3) @(negedge clk);
    check("R1 sof after reset", int'(sof_pulse), 0);
    check("R1 glitch after reset", int'(glitch_pulse), 0);
    rst_n = 1'b1;
    settle(4);
    check("R1 sof idle", int'(sof_pulse), 0);

    for (int i = 0; i < NV; i++) begin
      settle(4);
      cfg      = TW'(VEC[i].cfg);
      sof_en   = VEC[i].en;
      bus_idle = VEC[i].idle;
      p  = used_pos(int'(VEC[i].cfg));
      eg = (int'(VEC[i].len) < p) ? int'(VEC[i].len) : p;
      pulse_run(int'(VEC[i].len), WIN, 1'b0, ns, fs, ng, fg);
      check($sformatf("R2/R3/R10 vec%0d sof count", i), ns, int'(VEC[i].xs));
      check($sformatf("R3/R4/R10 vec%0d glitch count", i), ng, int'(VEC[i].xg));
      if (VEC[i].xs) check($sformatf("R2/R8 vec%0d sof cycle", i), fs, p + 3);
      if (VEC[i].xg) check($sformatf("R3 vec%0d glitch cycle", i), fg, eg + 3);
    end

    // R6: in-frame edges ignored until bus idle returns
    sof_en = 1'b1; cfg = TW'(8);
    settle(4);
    pulse_run(20, 24, 1'b1, ns, fs, ng, fg);
    check("R6 first frame sof", ns, 1);
    repeat (3) @(negedge clk);
    pulse_run(20, WIN, 1'b0, ns, fs, ng, fg);
    check("R6 edge in frame sof", ns, 0);
    check("R6 edge in frame glitch", ng, 0);
    settle(4);
    pulse_run(20, WIN, 1'b0, ns, fs, ng, fg);
    check("R6 rearmed sof", ns, 1);
    check("R6 rearmed sof cycle", fs, 11);

    // R9: quanta at half rate stretch the sample point
    tick_half = 1'b1;
    settle(4);
    pulse_run(30, WIN, 1'b0, ns, fs, ng, fg);
    check("R9 slow sof count", ns, 1);
    check("R9 slow sof later than fast", int'(fs > 11), 1);
    settle(4);
    pulse_run(10, WIN, 1'b0, ns, fs, ng, fg);
    check("R9 slow short pulse sof", ns, 0);
    check("R9 slow short pulse glitch", ng, 1);
    tick_half = 1'b0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule